// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer with Memory-Driven Sweep

This block generates a digital sine wave from a 24-bit phase accumulator. On every sample clock the accumulator advances by a tuning word, so the output frequency is the tuning word times the clock rate divided by 2^24. The frequency step is therefore the clock rate over 2^24. The upper twelve accumulator bits address a quarter-wave amplitude table. Quadrant folding rebuilds the full period as a 14-bit signed sample.

The tuning word comes from one of two places. In fixed mode it is the concatenation of a coarse register field and a fine register field. In sweep mode a 14-bit entry supplied by an external pattern memory forms the upper part of the word. The fine register field supplies the rest. This lets the frequency change within a pattern period.

The block raises a one-cycle strobe each time the accumulator MSB goes from 0 to 1. A memory address counter outside the block can step on that strobe. Each swept frequency then lasts exactly one output cycle, which produces a chirp.

Top module: `dds_sweep_synth`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `sine_out` is 0 and `phase_msb_rise` is 0.
- R2: With `sweep_en` = 0 the tuning word is {`tw_upper`, `tw_lower`}. `tw_upper` forms bits [23:12] and `tw_lower` forms bits [11:0].
- R3: With `sweep_en` = 1 the tuning word is {`mem_entry`, `tw_lower[9:0]`}. `mem_entry` forms bits [23:10]. `tw_upper` and `tw_lower[11:10]` have no effect on the phase.
- R4: The word presented before clock edge k is captured at edge k and added to `phase` at edge k+1. A change of word never clears or reloads `phase`.
- R5: `phase` wraps modulo 2^24. With a word of 0x400000, `phase` returns to the same value every 4 cycles.
- R6: `phase_msb_rise` is high for exactly the cycles in which `phase[23]` is 1 and was 0 in the previous cycle. It is never high in two consecutive cycles.
- R7: Let p be the value of `phase[23:12]` three cycles earlier. `sine_out` is within 16 LSB of 8191·sin(2π(p+0.5)/4096).
- R8: The sample for p and the sample for p+2048 are exact negatives of each other.
- R9: The sample for p and the sample for 2047−p are exactly equal, for p in 0..1023.
- R10: `sine_out` stays in −8191..+8191 and never takes the value −8192.
- R11: A tuning word of 0 holds `phase` constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tw_upper | input | 12 | Coarse register field, word bits [23:12] in fixed mode |
| tw_lower | input | 12 | Fine register field; all 12 bits used in fixed mode, bits [9:0] in sweep mode |
| sweep_en | input | 1 | 1 selects the memory-merged word, 0 the register word |
| mem_entry | input | 14 | Pattern memory entry, word bits [23:10] in sweep mode |
| phase | output | 24 | Accumulator value |
| phase_msb_rise | output | 1 | One-cycle strobe on each 0-to-1 transition of the accumulator MSB |
| sine_out | output | 14 | Signed sine sample, two's complement |

## Verification
The assertions check three things on every cycle:
- each accumulator step equals the captured word;
- the captured word matches the selected source in both modes;
- the MSB strobe matches the edge of the MSB, never repeats, and a zero word freezes the phase, while the sample never reaches the negative extreme.

Only the bench scenarios can show the following:
- the amplitude against an ideal sine over a full 4096-step sweep;
- the exact odd and mirror symmetries across the table;
- the four-cycle wrap at a quarter-turn word;
- that ignored register bits leave the phase sequence unchanged.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Rounded magnitude of one quarter-wave table entry.
  // Uses a rational sine approximation evaluated at the centre of bin idx.
  // u = (2*idx+1)/(2*qlen) spans (0,1) over a quarter turn;
  // sin ~= 4*u*(2-u) / (5 - u*(2-u)).
  function automatic longint qsin_amp(input int unsigned idx,
                                      input int unsigned qlen,
                                      input int unsigned amp);
    longint d;
    longint u;
    longint p;
    longint num;
    longint den;
    d   = 2 * longint'(qlen);
    u   = 2 * longint'(idx) + 1;
    p   = u * (2 * d - u);
    num = 4 * longint'(amp) * p;
    den = 5 * d * d - p;
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/dds_tw_select.sv
module dds_tw_select #(
  parameter int TW_W  = 24,
  parameter int HI_W  = 12,
  parameter int MEM_W = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HI_W-1:0]        tw_upper,
  input  logic [TW_W-HI_W-1:0]   tw_lower,
  input  logic                   sweep_en,
  input  logic [MEM_W-1:0]       mem_entry,
  output logic [TW_W-1:0]        tw_active
);
  localparam int FINE_W = TW_W - MEM_W;

  logic [TW_W-1:0] reg_word;
  logic [TW_W-1:0] swept_word;
  logic [TW_W-1:0] tw_next;

  assign reg_word   = {tw_upper, tw_lower};
  assign swept_word = {mem_entry, tw_lower[FINE_W-1:0]};
  assign tw_next    = sweep_en ? swept_word : reg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tw_active <= '0;
    else        tw_active <= tw_next;
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int TW_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW_W-1:0] tw,
  output logic [TW_W-1:0] phase_q,
  output logic            msb_rise
);
  logic msb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      msb_d   <= 1'b0;
    end else begin
      phase_q <= phase_q + tw;
      msb_d   <= phase_q[TW_W-1];
    end
  end

  assign msb_rise = phase_q[TW_W-1] & ~msb_d;
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom
  import dds_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;
  localparam int PEAK  = (1 << DW) - 1;

  logic [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = DW'(qsin_amp(g, DEPTH, PEAK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= tbl[addr];
  end
endmodule

// File: rtl/dds_sine_shaper.sv
module dds_sine_shaper #(
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LUT_AW+1:0]       phase_top,
  output logic signed [AMP_W-1:0] sine_q
);
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr_s1;
  logic              neg_s1;
  logic              neg_s2;
  logic [AMP_W-2:0]  mag_s2;
  logic [AMP_W-1:0]  mag_ext;

  assign quad = phase_top[LUT_AW+1:LUT_AW];
  assign idx  = phase_top[LUT_AW-1:0];

  // stage 1: fold into the first quadrant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_s1 <= '0;
      neg_s1  <= 1'b0;
    end else begin
      addr_s1 <= quad[0] ? ~idx : idx;
      neg_s1  <= quad[1];
    end
  end

  // stage 2: table read (registered inside the table)
  dds_quarter_rom #(.AW(LUT_AW), .DW(AMP_W-1)) u_rom (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr_s1),
    .data (mag_s2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) neg_s2 <= 1'b0;
    else        neg_s2 <= neg_s1;
  end

  // stage 3: restore sign
  assign mag_ext = {1'b0, mag_s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sine_q <= '0;
    else        sine_q <= neg_s2 ? (~mag_ext + 1'b1) : mag_ext;
  end
endmodule

// File: rtl/dds_sweep_synth.sv
module dds_sweep_synth #(
  parameter int TW_W   = 24,
  parameter int HI_W   = 12,
  parameter int MEM_W  = 14,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HI_W-1:0]         tw_upper,
  input  logic [TW_W-HI_W-1:0]    tw_lower,
  input  logic                    sweep_en,
  input  logic [MEM_W-1:0]        mem_entry,
  output logic [TW_W-1:0]         phase,
  output logic                    phase_msb_rise,
  output logic signed [AMP_W-1:0] sine_out
);
  localparam int PT_W = LUT_AW + 2;

  logic [TW_W-1:0] tw_active;
  logic [TW_W-1:0] phase_q;
  logic            msb_rise_w;
  logic [PT_W-1:0] phase_top;

  dds_tw_select #(.TW_W(TW_W), .HI_W(HI_W), .MEM_W(MEM_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .tw_upper (tw_upper),
    .tw_lower (tw_lower),
    .sweep_en (sweep_en),
    .mem_entry(mem_entry),
    .tw_active(tw_active)
  );

  dds_phase_acc #(.TW_W(TW_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tw      (tw_active),
    .phase_q (phase_q),
    .msb_rise(msb_rise_w)
  );

  assign phase_top = phase_q[TW_W-1 -: PT_W];

  dds_sine_shaper #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_top(phase_top),
    .sine_q   (sine_out)
  );

  assign phase          = phase_q;
  assign phase_msb_rise = msb_rise_w;
endmodule

// File: rtl/dds_sweep_chk.sv
module dds_sweep_chk #(
  parameter int TW_W  = 24,
  parameter int HI_W  = 12,
  parameter int MEM_W = 14,
  parameter int AMP_W = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [HI_W-1:0]         tw_upper,
  input logic [TW_W-HI_W-1:0]    tw_lower,
  input logic                    sweep_en,
  input logic [MEM_W-1:0]        mem_entry,
  input logic [TW_W-1:0]         tw_active,
  input logic [TW_W-1:0]         phase,
  input logic                    phase_msb_rise,
  input logic signed [AMP_W-1:0] sine_out
);
  localparam int FINE_W = TW_W - MEM_W;
  localparam logic [AMP_W-1:0] NEG_EXT = {1'b1, {(AMP_W-1){1'b0}}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (phase == '0 && !phase_msb_rise && sine_out == '0));

  // R2
  fixed_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |=> tw_active == {$past(tw_upper), $past(tw_lower)});

  // R3
  sweep_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en |=> (tw_active[TW_W-1:FINE_W] == $past(mem_entry) &&
                  tw_active[FINE_W-1:0] == $past(tw_lower[FINE_W-1:0])));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == TW_W'($past(phase) + $past(tw_active)));

  // R6
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_msb_rise |-> (phase[TW_W-1] && !$past(phase[TW_W-1])));

  // R6
  rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[TW_W-1] && !$past(phase[TW_W-1])) |-> phase_msb_rise);

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_msb_rise |=> !phase_msb_rise);

  // R10
  sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sine_out != NEG_EXT);

  // R11
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_active == '0) |=> $stable(phase));
endmodule

bind dds_sweep_synth dds_sweep_chk #(
  .TW_W(TW_W), .HI_W(HI_W), .MEM_W(MEM_W), .AMP_W(AMP_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tw_upper      (tw_upper),
  .tw_lower      (tw_lower),
  .sweep_en      (sweep_en),
  .mem_entry     (mem_entry),
  .tw_active     (tw_active),
  .phase         (phase),
  .phase_msb_rise(phase_msb_rise),
  .sine_out      (sine_out)
);

// File: tb/tb_dds_sweep_synth.sv
`timescale 1ns/1ps
module tb_dds_sweep_synth;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [11:0]        tw_upper = '0;
  logic [11:0]        tw_lower = '0;
  logic               sweep_en = 1'b0;
  logic [13:0]        mem_entry = '0;
  logic [23:0]        phase;
  logic               phase_msb_rise;
  logic signed [13:0] sine_out;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // bench model of the phase, built from R2..R4
  logic [23:0] m_phase = '0;
  logic [23:0] m_tw    = '0;
  logic [23:0] m_prev  = '0;
  logic [23:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;

  int sample_at [4096];

  always #10 clk = ~clk;

  dds_sweep_synth dut (
    .clk(clk), .rst_n(rst_n), .tw_upper(tw_upper), .tw_lower(tw_lower),
    .sweep_en(sweep_en), .mem_entry(mem_entry), .phase(phase),
    .phase_msb_rise(phase_msb_rise), .sine_out(sine_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] word_now();
    return sweep_en ? {mem_entry, tw_lower[9:0]} : {tw_upper, tw_lower};
  endfunction

  task automatic tick();
    logic [23:0] w;
    w = word_now();
    @(posedge clk);
    @(negedge clk);
    m_prev  = m_phase;
    m_phase = m_phase + m_tw;
    m_tw    = w;
    h3 = h2; h2 = h1; h1 = h0; h0 = m_phase;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(phase == 24'd0, "R1 phase", phase, 0);
    chk(sine_out == 14'sd0, "R1 sine_out", sine_out, 0);
    chk(phase_msb_rise == 1'b0, "R1 rise", phase_msb_rise, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fixed();
    logic [23:0] p;
    sweep_en = 1'b0; tw_upper = 12'h012; tw_lower = 12'h345;
    tick();
    chk(phase == 24'd0, "R4 word not yet applied", phase, 0);
    tick();
    chk(phase == 24'h012345, "R2 first step", phase, 24'h012345);
    repeat (5) tick();
    chk(phase == m_phase, "R2 fixed run", phase, m_phase);
    p = phase;
    tw_upper = 12'h0A0; tw_lower = 12'h001;
    tick();
    chk(phase == p + 24'h012345, "R4 old word one more cycle", phase, p + 24'h012345);
    tick();
    chk(phase == p + 24'h012345 + 24'h0A0001, "R4 no phase reload", phase,
        p + 24'h012345 + 24'h0A0001);
  endtask

  task automatic t_sweep();
    logic [23:0] w;
    logic [23:0] p;
    sweep_en = 1'b1; mem_entry = 14'h2AAA; tw_upper = 12'hFFF; tw_lower = 12'hFC5;
    w = {14'h2AAA, 10'h3C5};
    tick(); tick();
    p = phase;
    tick();
    chk(phase == p + w, "R3 merged step", phase, p + w);
    tw_upper = 12'h000; tw_lower = 12'h3C5;
    tick(); p = phase; tick();
    chk(phase == p + w, "R3 upper and lower[11:10] ignored", phase, p + w);
    for (int i = 0; i < 6; i++) begin
      mem_entry = 14'(i * 14'h0333 + 1);
      tick();
    end
    tick();
    chk(phase == m_phase, "R3 changing entries", phase, m_phase);
    sweep_en = 1'b0;
  endtask

  task automatic t_wrap();
    logic [23:0] p;
    tw_upper = 12'h400; tw_lower = 12'h000;
    tick(); tick();
    p = phase;
    tick();
    chk(phase == p + 24'h400000, "R5 quarter step", phase, p + 24'h400000);
    repeat (3) tick();
    chk(phase == p, "R5 wrap after 4", phase, p);
  endtask

  task automatic t_rise();
    int n = 0;
    int bad = 0;
    tw_upper = 12'h100; tw_lower = 12'h000;
    tick(); tick();
    for (int i = 0; i < 64; i++) begin
      tick();
      if (phase_msb_rise) n++;
      if (phase_msb_rise != (m_phase[23] & ~m_prev[23])) bad++;
    end
    chk(bad == 0, "R6 strobe matches MSB edge", bad, 0);
    chk(n == 4, "R6 strobes per 4 turns", n, 4);
  endtask

  task automatic t_zero();
    logic [23:0] p;
    tw_upper = 12'h000; tw_lower = 12'h000;
    tick(); tick();
    p = phase;
    repeat (10) tick();
    chk(phase == p, "R11 zero word holds", phase, p);
  endtask

  task automatic t_sine();
    int bad = 0;
    int worst = 0;
    int asym = 0;
    int mirr = 0;
    int lowest = 0;
    tw_upper = 12'h001; tw_lower = 12'h000;
    repeat (5) tick();
    for (int i = 0; i < 4096; i++) begin
      int s;
      int p12;
      real e;
      real d;
      tick();
      s   = int'(sine_out);
      p12 = int'(h3[23:12]);
      e   = 8191.0 * $sin(2.0 * 3.14159265358979 * (real'(p12) + 0.5) / 4096.0);
      d   = real'(s) - e;
      if (d < 0.0) d = -d;
      if (d > 16.0) begin
        bad++;
        if (int'(d) > worst) worst = int'(d);
      end
      if (s == -8192) lowest++;
      sample_at[p12] = s;
    end
    chk(bad == 0, "R7 amplitude within 16 LSB (worst dev)", worst, 16);
    chk(lowest == 0, "R10 no -8192 sample", lowest, 0);
    for (int p = 0; p < 2048; p++)
      if (sample_at[p] != -sample_at[p + 2048]) asym++;
    chk(asym == 0, "R8 half-turn negation", asym, 0);
    for (int p = 0; p < 1024; p++)
      if (sample_at[p] != sample_at[2047 - p]) mirr++;
    chk(mirr == 0, "R9 quarter mirror", mirr, 0);
    chk(sample_at[1023] > 8180, "R7 peak near +8191", sample_at[1023], 8191);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_sweep();
    t_wrap();
    t_rise();
    t_zero();
    t_sine();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule